// File: doc/BRIEF.md
# Register-Programmed Update Timer

This block is a general-purpose up-counting timer that software drives over a word-wide register bus. A programmable divider slows the input clock into count ticks. The main counter climbs from zero to a programmable limit. When it reaches the limit and the next tick arrives, the block raises an update event. The update event returns the counter to zero, sets a status flag and, when enabled, drives the interrupt line. The timer either keeps running to give periodic events, or it halts itself after one event, which gives a single delayed interrupt.

The divider value always passes through a shadow copy, which takes effect only at an update event. The limit can take effect at once, or it can wait in a shadow copy when preload is enabled. Software can force an update event to restart the count and load both shadows. The counter width is 16 or 32 bits. Software can find the width by writing all ones to the limit register and reading it back.

Run control is a two-state machine, ST_HALT and ST_RUN, with three transitions:
- START: a control write with the run bit set, taken in ST_HALT.
- SW_STOP: a control write with the run bit clear, taken in ST_RUN.
- ONESHOT_END: a natural update event while single-shot mode is selected and no control write happens in the same cycle.

Top module: `upd_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Registers sit at these byte addresses: control 0x00, interrupt enable 0x0C, status 0x10, event 0x14, divider 0x28 and limit 0x2C. Control bit 0 is run, bit 3 is single-shot and bit 7 is limit preload. Bit 0 is the only field of interrupt enable, status and event. Unused bits and unmapped addresses read zero.
- R3: Start the timer with the counter and the divider count both at zero. The first update event then occurs (limit+1)*(divider+1) clocks after the edge that captures the start write. The event returns the counter to zero and sets status bit 0.
- R4: With single-shot clear, update events repeat every (limit+1)*(divider+1) clocks.
- R5: With single-shot set, the update event clears the run bit and no further events occur.
- R6: A written divider value takes effect only at the next update event, either natural or forced.
- R7: With preload clear, a limit write takes effect at once. With preload set, it takes effect only at the next update event.
- R8: Writing 1 to event bit 0 forces an update event. The forced event zeroes the counter and the divider count, loads both shadows and sets status bit 0. The event register always reads zero.
- R9: `irq` equals status bit 0 AND interrupt-enable bit 0. Writing 0 to status bit 0 clears the flag. Writing 1 to status bit 0 leaves the flag unchanged.
- R10: When an update event and a status-clear write fall in the same cycle, the flag ends set.
- R11: The limit register is as wide as the counter: all ones written reads back as 0x0000FFFF when the width is 16. The divider register is 16 bits wide.
- R12: While the run bit is clear, the counter holds and no natural update event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Update interrupt |

## Verification
A natural update event can set the status flag in the same cycle that software writes zero to clear it. The bench starts a period of known length and waits a counted number of edges. It then issues the status-clear write so that the write is captured on exactly the edge of the update event. Afterwards the bench reads status and observes `irq`: both must show the flag set, because the hardware event takes priority over the software clear.

// File: rtl/utm_pkg.sv
package utm_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EVT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_TOP  = 8'h2C;

    localparam int B_RUN     = 0;
    localparam int B_SINGLE  = 3;
    localparam int B_PRELOAD = 7;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/utm_presc.sv
module utm_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             load,
    input  logic [PSC_W-1:0] div_val,
    output logic             tick
);
    logic [PSC_W-1:0] div_cnt;
    logic [PSC_W-1:0] div_act;

    assign tick = enable && (div_cnt == div_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            div_act <= '0;
        end else if (clear) begin
            div_cnt <= '0;
            div_act <= div_val;
        end else if (tick) begin
            div_cnt <= '0;
            if (load) div_act <= div_val;
        end else if (enable) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R3: divider count never passes its active ratio
    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= div_act);
endmodule

// File: rtl/utm_core.sv
module utm_core
    import utm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             run_wdata,
    input  logic             single,
    input  logic             preload,
    input  logic             force_upd,
    input  logic [PSC_W-1:0] div_reg,
    input  logic [CNT_W-1:0] top_reg,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    output logic             running,
    output logic             upd_any
);
    run_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_act;
    logic             tick;
    logic             nat_upd;

    assign nat_upd = tick && (cnt == top_act);
    assign upd_any = nat_upd || force_upd;

    utm_presc #(.PSC_W(PSC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state == ST_RUN),
        .clear   (force_upd),
        .load    (nat_upd),
        .div_val (div_reg),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // transitions: START, SW_STOP, ONESHOT_END
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (ctrl_wr && run_wdata) state_nx = ST_RUN;
            ST_RUN: begin
                if (ctrl_wr)                 state_nx = run_wdata ? ST_RUN : ST_HALT;
                else if (nat_upd && single)  state_nx = ST_HALT;
            end
        endcase
    end

    // outputs
    always_comb begin
        running = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (force_upd) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == top_act) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  top_act <= '0;
        else if (top_wr && !preload) top_act <= top_wdata;
        else if (upd_any)            top_act <= top_reg;
    end

    // R5: single-shot update with no concurrent control write halts the timer
    assert_single_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nat_upd && single && !ctrl_wr) |=> (state == ST_HALT));
    // R8: forced update leaves the counter at zero
    assert_forced_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (cnt == '0));
    // R12: a halted counter holds unless forced
    assert_halt_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !force_upd) |=> $stable(cnt));
endmodule

// File: rtl/utm_regs.sv
module utm_regs
    import utm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              running,
    input  logic              upd_any,
    output logic              ctrl_wr,
    output logic              single,
    output logic              preload,
    output logic              force_upd,
    output logic [PSC_W-1:0]  div_reg,
    output logic [CNT_W-1:0]  top_reg,
    output logic              top_wr,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic uie;
    logic uif;
    logic stat_wr;

    assign ctrl_wr   = bus_we && (bus_addr == OFS_CTRL);
    assign stat_wr   = bus_we && (bus_addr == OFS_STAT);
    assign top_wr    = bus_we && (bus_addr == OFS_TOP);
    assign force_upd = bus_we && (bus_addr == OFS_EVT) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single  <= 1'b0;
            preload <= 1'b0;
            uie     <= 1'b0;
            div_reg <= '0;
            top_reg <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    single  <= bus_wdata[B_SINGLE];
                    preload <= bus_wdata[B_PRELOAD];
                end
                OFS_IEN: uie     <= bus_wdata[0];
                OFS_DIV: div_reg <= bus_wdata[PSC_W-1:0];
                OFS_TOP: top_reg <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // hardware set outranks software clear
    always_ff @(posedge clk) begin
        if (!rst_n)                        uif <= 1'b0;
        else if (upd_any)                  uif <= 1'b1;
        else if (stat_wr && !bus_wdata[0]) uif <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[B_RUN]     = running;
                bus_rdata[B_SINGLE]  = single;
                bus_rdata[B_PRELOAD] = preload;
            end
            OFS_IEN:  bus_rdata[0] = uie;
            OFS_STAT: bus_rdata[0] = uif;
            OFS_DIV:  bus_rdata[PSC_W-1:0] = div_reg;
            OFS_TOP:  bus_rdata[CNT_W-1:0] = top_reg;
            default:  bus_rdata = '0;
        endcase
        irq = uif && uie;
    end

    // R10: every update event leaves the flag set
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_any |=> uif);
    // R9: a status write of one never clears the flag
    assert_one_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uif && stat_wr && bus_wdata[0]) |=> uif);
endmodule

// File: rtl/upd_timer.sv
module upd_timer
    import utm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic             ctrl_wr, single, preload, force_upd, top_wr;
    logic             running, upd_any;
    logic [PSC_W-1:0] div_reg;
    logic [CNT_W-1:0] top_reg;

    utm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .running   (running),
        .upd_any   (upd_any),
        .ctrl_wr   (ctrl_wr),
        .single    (single),
        .preload   (preload),
        .force_upd (force_upd),
        .div_reg   (div_reg),
        .top_reg   (top_reg),
        .top_wr    (top_wr),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    utm_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .run_wdata (bus_wdata[B_RUN]),
        .single    (single),
        .preload   (preload),
        .force_upd (force_upd),
        .div_reg   (div_reg),
        .top_reg   (top_reg),
        .top_wr    (top_wr),
        .top_wdata (bus_wdata[CNT_W-1:0]),
        .running   (running),
        .upd_any   (upd_any)
    );
endmodule

// File: tb/sim_upd_timer.sv
module sim_upd_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                           A_EVT = 8'h14, A_DIV = 8'h28, A_TOP = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit rd_pend = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    upd_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: pops expected read items and compares
    always @(negedge clk) begin
        exp_t e;
        if (rd_pend && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (bus_rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: read %h expected %h", e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // all tasks start just after a rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_addr = a; rd_pend = 1'b1;
        sb_q.push_back('{exp: d, tag: tag});
        @(posedge clk); #1;
        rd_pend = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!irq && n < 1000);
    endtask

    task automatic park();
        wr(A_CTRL, 32'h0);
        wr(A_DIV, 32'h0);
        wr(A_EVT, 32'h1);
        wr(A_STAT, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd(A_CTRL, 0, "R1 ctrl"); rd(A_IEN, 0, "R1 ien"); rd(A_STAT, 0, "R1 stat");
        rd(A_DIV, 0, "R1 div"); rd(A_TOP, 0, "R1 top");
        chk("R1 irq", irq, 0);

        // R11 and R2 widths, bits, unmapped
        wr(A_TOP, 32'hFFFF_FFFF); rd(A_TOP, 32'h0000_FFFF, "R11 top width");
        wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, 32'h0000_FFFF, "R11 div width");
        wr(A_CTRL, 32'h0000_FF88); rd(A_CTRL, 32'h88, "R2 ctrl bits");
        rd(8'h34, 0, "R2 unmapped"); rd(A_EVT, 0, "R8 evt reads zero");
        wr(A_CTRL, 0);

        // R8 forced update, R9 gating and clearing
        wr(A_DIV, 0); wr(A_TOP, 3); wr(A_EVT, 1);
        rd(A_STAT, 1, "R8 forced sets flag");
        chk("R9 irq gated", irq, 0);
        wr(A_IEN, 1); chk("R9 irq enabled", irq, 1);
        wr(A_STAT, 1); chk("R9 write one keeps", irq, 1);
        wr(A_STAT, 0); chk("R9 write zero clears", irq, 0);

        // R3 / R4 periodic
        wr(A_CTRL, 1);
        wait_irq(n); chk("R3 first period", n, 4);
        wr(A_STAT, 0);
        wait_irq(n); chk("R4 second period", n, 3);
        park();
        edges(12); chk("R12 halted no event", irq, 0);

        // R6 divider shadow
        wr(A_DIV, 2);
        wr(A_CTRL, 1);
        wait_irq(n); chk("R6 old divider", n, 4);
        wr(A_STAT, 0);
        wait_irq(n); chk("R6 new divider", n, 11);
        park();

        // R7 immediate and preloaded limit
        wr(A_TOP, 5);
        wr(A_CTRL, 1);
        wait_irq(n); chk("R7 immediate limit", n, 6);
        park();
        wr(A_CTRL, 32'h80); wr(A_TOP, 9); wr(A_CTRL, 32'h81);
        wait_irq(n); chk("R7 preload old limit", n, 6);
        wr(A_STAT, 0);
        wait_irq(n); chk("R7 preload new limit", n, 9);
        park();

        // R5 single shot
        wr(A_TOP, 2);
        wr(A_CTRL, 32'h09);
        wait_irq(n); chk("R5 single period", n, 3);
        rd(A_CTRL, 32'h08, "R5 run bit cleared");
        wr(A_STAT, 0);
        edges(15); chk("R5 no further event", irq, 0);
        park();

        // R10 clear collides with update
        wr(A_CTRL, 1);
        edges(2);
        wr(A_STAT, 0);
        rd(A_STAT, 1, "R10 set beats clear");
        chk("R10 irq held", irq, 1);
        park();

        // R8 forced update restarts the count
        wr(A_TOP, 3);
        wr(A_CTRL, 1);
        edges(1);
        wr(A_EVT, 1);
        wr(A_STAT, 0);
        wait_irq(n); chk("R8 restart from zero", n, 3);
        park();

        edges(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule